// File: doc/BRIEF.md
# Warp Memory Request Address Coalescer

This block takes one memory request from a warp, where every thread lane supplies its own byte address and an active bit, and folds the lane accesses into the smallest set of aligned 128-byte memory transactions. Lanes whose addresses land in the same aligned segment share a single transaction. Each transaction goes out with the segment base address and a lane mask that names the lanes it serves. Transactions leave one per cycle over a valid/ready handshake.

Every accepted request takes an entry in a small pending table. That entry counts the transactions sent for the request and removes one from the count for each response that returns with the entry's tag. When all transactions for a request have been sent and all their responses have come back, the block pulses a completion with the warp ID and frees the entry. The memory system and the data return path sit outside the block. Only the tag of each response comes back here.

Top module: `mem_coalescer`

## Requirements
- R1: Active lanes whose addresses share bits [31:7] are served by one transaction, and `tx_base` is that segment's address with bits [6:0] zero. A request needs exactly as many transactions as it has distinct active segments.
- R2: Transactions are emitted in order of the lowest-numbered active lane not yet covered. Bit i of `tx_tmask` is set exactly when lane i is active, not yet covered, and in the leading lane's segment.
- R3: Inactive lanes never appear in any `tx_tmask`. No lane appears in two transactions, and after the last transaction `tx_valid` falls.
- R4: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_base`, `tx_tmask` and `tx_tag` hold their values.
- R5: The first transaction of a request with a nonzero mask is valid in the cycle after acceptance. With `tx_ready` held high, the next transaction follows in every cycle.
- R6: A request with an all-zero active mask emits no transaction. `done_valid` is high with its warp ID in the cycle after acceptance.
- R7: An accepted request takes the lowest-numbered free table entry, and each of its transactions carries that index on `tx_tag`. Each `rsp_valid` takes one from the count of entry `rsp_tag`. When sending has ended and the count is zero, `done_valid` is high for one cycle with `done_wid` and `done_tag`, and then the entry is freed.
- R8: `req_ready` is low while a request is still emitting transactions and while every table entry is in use. A request offered while `req_ready` is low is ignored.
- R9: After reset `req_ready` is high, and `tx_valid` and `done_valid` are low.
- R10: `tx_size` carries the access size of the request that is being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_wid | input | WID_W | Warp ID of the request |
| req_size | input | SIZE_W | Access size code, passed through |
| req_mask | input | NUM_THREADS | Per-lane active bits |
| req_addr | input | NUM_THREADS*ADDR_W | Per-lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Memory side takes the transaction |
| tx_base | output | ADDR_W | Aligned segment base address |
| tx_tmask | output | NUM_THREADS | Lanes served by this transaction |
| tx_size | output | SIZE_W | Access size of the request |
| tx_tag | output | TAG_W | Pending table index |
| rsp_valid | input | 1 | One transaction response returned |
| rsp_tag | input | TAG_W | Table index of the response |
| done_valid | output | 1 | A request has fully completed |
| done_wid | output | WID_W | Warp ID of the completed request |
| done_tag | output | TAG_W | Table index being freed |

## Verification
Acceptance happens at the rising edge where `req_valid` and `req_ready` are both high. One register stage later the first transaction is on the `tx_*` outputs. Each handshake edge moves to the next transaction, and a response edge makes `done_valid` visible in the following cycle with no extra delay. The bench drives inputs and samples outputs on the falling edge. After a request it expects the first transaction at the very next falling edge, then one new transaction per falling edge while `tx_ready` is high, and a completion at the falling edge right after the final response or right after a zero-mask acceptance. It also checks at the falling edge after that, where `done_valid` must have dropped.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    CO_IDLE = 1'b0,
    CO_EMIT = 1'b1
  } co_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/coal_lowest_pick.sv
module coal_lowest_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = coal_pkg::idx_width(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/coal_segment_group.sv
module coal_segment_group #(
  parameter int unsigned NT     = 8,
  parameter int unsigned AW     = 32,
  parameter int unsigned SEG_LG = 7,
  localparam int unsigned SW    = AW - SEG_LG,
  localparam int unsigned LW    = coal_pkg::idx_width(NT)
) (
  input  logic [NT-1:0]    remain,
  input  logic [NT*AW-1:0] addr_flat,
  output logic             any,
  output logic [NT-1:0]    grp_mask,
  output logic [AW-1:0]    seg_base
);

  logic [SW-1:0] seg [NT];
  logic [SW-1:0] lead_seg;
  logic [LW-1:0] lead_idx;

  coal_lowest_pick #(.N(NT)) u_lead (
    .vec (remain),
    .any (any),
    .idx (lead_idx)
  );

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_lane
      assign seg[g]      = addr_flat[g*AW + SEG_LG +: SW];
      assign grp_mask[g] = remain[g] && (seg[g] == lead_seg);
    end
  endgenerate

  always_comb begin
    lead_seg = '0;
    for (int i = 0; i < NT; i++) begin
      if (lead_idx == LW'(i)) lead_seg = seg[i];
    end
  end

  assign seg_base = {lead_seg, {SEG_LG{1'b0}}};

endmodule

// File: rtl/coal_pending_table.sv
module coal_pending_table #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned WID_W = 4,
  localparam int unsigned IW   = coal_pkg::idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [WID_W-1:0] alloc_wid,
  input  logic             alloc_open,
  output logic             free_any,
  output logic [IW-1:0]    free_idx,
  input  logic             inc_en,
  input  logic [IW-1:0]    inc_tag,
  input  logic             inc_last,
  input  logic             dec_en,
  input  logic [IW-1:0]    dec_tag,
  output logic             done_valid,
  output logic [IW-1:0]    done_tag,
  output logic [WID_W-1:0] done_wid
);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [DEPTH-1:0] open_q, open_d;
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] cnt_d [DEPTH];
  logic [WID_W-1:0] wid_q [DEPTH];
  logic [DEPTH-1:0] retire_vec;
  logic [DEPTH-1:0] wid_en;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_ret
      assign retire_vec[g] = vld_q[g] && !open_q[g] && (cnt_q[g] == '0);
      assign wid_en[g]     = alloc_en && (free_idx == IW'(g));
    end
  endgenerate

  coal_lowest_pick #(.N(DEPTH)) u_free (
    .vec (~vld_q),
    .any (free_any),
    .idx (free_idx)
  );

  coal_lowest_pick #(.N(DEPTH)) u_retire (
    .vec (retire_vec),
    .any (done_valid),
    .idx (done_tag)
  );

  always_comb begin
    done_wid = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (done_tag == IW'(e)) done_wid = wid_q[e];
    end
  end

  always_comb begin
    vld_d  = vld_q;
    open_d = open_q;
    for (int e = 0; e < DEPTH; e++) begin
      cnt_d[e] = cnt_q[e];
      if (done_valid && done_tag == IW'(e)) vld_d[e] = 1'b0;
      if (wid_en[e]) begin
        vld_d[e]  = 1'b1;
        open_d[e] = alloc_open;
        cnt_d[e]  = '0;
      end else begin
        if (inc_en && inc_tag == IW'(e)) begin
          cnt_d[e] = cnt_d[e] + CNT_W'(1);
          if (inc_last) open_d[e] = 1'b0;
        end
        if (dec_en && dec_tag == IW'(e)) cnt_d[e] = cnt_d[e] - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      open_q <= '0;
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= '0;
    end else begin
      vld_q  <= vld_d;
      open_q <= open_d;
      for (int e = 0; e < DEPTH; e++) cnt_q[e] <= cnt_d[e];
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (wid_en[e]) wid_q[e] <= alloc_wid;
    end
  end

endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned SEG_LG      = 7,
  parameter int unsigned TABLE_DEPTH = 4,
  parameter int unsigned WID_W       = 4,
  parameter int unsigned SIZE_W      = 2,
  localparam int unsigned TAG_W      = coal_pkg::idx_width(TABLE_DEPTH),
  localparam int unsigned CNT_W      = $clog2(NUM_THREADS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [WID_W-1:0]              req_wid,
  input  logic [SIZE_W-1:0]             req_size,
  input  logic [NUM_THREADS-1:0]        req_mask,
  input  logic [NUM_THREADS*ADDR_W-1:0] req_addr,
  output logic                          tx_valid,
  input  logic                          tx_ready,
  output logic [ADDR_W-1:0]             tx_base,
  output logic [NUM_THREADS-1:0]        tx_tmask,
  output logic [SIZE_W-1:0]             tx_size,
  output logic [TAG_W-1:0]              tx_tag,
  input  logic                          rsp_valid,
  input  logic [TAG_W-1:0]              rsp_tag,
  output logic                          done_valid,
  output logic [WID_W-1:0]              done_wid,
  output logic [TAG_W-1:0]              done_tag
);

  import coal_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  co_state_e                     state_q, state_d;
  logic [NUM_THREADS-1:0]        remain_q, remain_d;
  logic [NUM_THREADS*ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0]             size_q;
  logic [TAG_W-1:0]              tag_q;

  logic                   load_en;
  logic                   tx_fire;
  logic                   last_tx;
  logic                   grp_any;
  logic [NUM_THREADS-1:0] grp_mask;
  logic [NUM_THREADS-1:0] remain_after;
  logic                   free_any;
  logic [TAG_W-1:0]       free_idx;

  coal_segment_group #(
    .NT     (NUM_THREADS),
    .AW     (ADDR_W),
    .SEG_LG (SEG_LG)
  ) u_group (
    .remain    (remain_q),
    .addr_flat (addr_q),
    .any       (grp_any),
    .grp_mask  (grp_mask),
    .seg_base  (tx_base)
  );

  coal_pending_table #(
    .DEPTH (TABLE_DEPTH),
    .CNT_W (CNT_W),
    .WID_W (WID_W)
  ) u_table (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .alloc_en   (load_en),
    .alloc_wid  (req_wid),
    .alloc_open (|req_mask),
    .free_any   (free_any),
    .free_idx   (free_idx),
    .inc_en     (tx_fire),
    .inc_tag    (tag_q),
    .inc_last   (last_tx),
    .dec_en     (rsp_valid),
    .dec_tag    (rsp_tag),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .done_wid   (done_wid)
  );

  assign req_ready    = (state_q == CO_IDLE) && free_any;
  assign load_en      = req_valid && req_ready;
  assign tx_valid     = (state_q == CO_EMIT) && grp_any;
  assign tx_fire      = tx_valid && tx_ready;
  assign remain_after = remain_q & ~grp_mask;
  assign last_tx      = (remain_after == '0);
  assign tx_tmask     = grp_mask;
  assign tx_size      = size_q;
  assign tx_tag       = tag_q;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    if (load_en) begin
      remain_d = req_mask;
      state_d  = (|req_mask) ? CO_EMIT : CO_IDLE;
    end else if (tx_fire) begin
      remain_d = remain_after;
      if (last_tx) state_d = CO_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= CO_IDLE;
      remain_q <= '0;
    end else begin
      state_q  <= state_d;
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= req_addr;
      size_q <= req_size;
      tag_q  <= free_idx;
    end
  end

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int unsigned NT    = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned TW    = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [NT-1:0] req_mask,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [AW-1:0] tx_base,
  input logic [NT-1:0] tx_tmask,
  input logic [TW-1:0] tx_tag,
  input logic          done_valid,
  input logic [TW-1:0] done_tag
);

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_tmask) && $stable(tx_tag));

  // R3
  tx_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_valid || ((tx_tmask & $past(tx_tmask)) == '0));

  // R5
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mask != '0) |=> tx_valid);

  // R6
  zero_mask_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mask == '0) |=> done_valid && !tx_valid);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  // R7
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !(done_valid && done_tag == $past(done_tag)));

endmodule

bind mem_coalescer coal_checker #(
  .NT (NUM_THREADS),
  .AW (ADDR_W),
  .TW (TAG_W)
) u_coal_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mask   (req_mask),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_base    (tx_base),
  .tx_tmask   (tx_tmask),
  .tx_tag     (tx_tag),
  .done_valid (done_valid),
  .done_tag   (done_tag)
);

// File: tb/test_mem_coalescer.sv
`timescale 1ns/1ps
module test_mem_coalescer;

  localparam int NT  = 8;
  localparam int AW  = 32;
  localparam int WW  = 4;
  localparam int SZW = 2;
  localparam int TW  = 2;

  logic            clk;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [WW-1:0]   req_wid;
  logic [SZW-1:0]  req_size;
  logic [NT-1:0]   req_mask;
  logic [NT*AW-1:0] req_addr;
  logic            tx_valid;
  logic            tx_ready;
  logic [AW-1:0]   tx_base;
  logic [NT-1:0]   tx_tmask;
  logic [SZW-1:0]  tx_size;
  logic [TW-1:0]   tx_tag;
  logic            rsp_valid;
  logic [TW-1:0]   rsp_tag;
  logic            done_valid;
  logic [WW-1:0]   done_wid;
  logic [TW-1:0]   done_tag;

  logic [AW-1:0] lane_addr [NT];
  int n_vec;
  int n_err;
  bit finished;

  mem_coalescer i_mem_coalescer (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_wid(req_wid),
    .req_size(req_size), .req_mask(req_mask), .req_addr(req_addr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_base(tx_base),
    .tx_tmask(tx_tmask), .tx_size(tx_size), .tx_tag(tx_tag),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .done_valid(done_valid), .done_wid(done_wid), .done_tag(done_tag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NT; i++) req_addr[i*AW +: AW] = lane_addr[i];
  end

  task automatic check_eq(input string rq, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic send_req(input logic [WW-1:0] wid, input logic [NT-1:0] mask, input logic [SZW-1:0] size);
    check_eq("R8", "req_ready before offer", req_ready, 1);
    req_valid = 1'b1; req_wid = wid; req_mask = mask; req_size = size;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_rsp(input logic [TW-1:0] tag);
    rsp_valid = 1'b1; rsp_tag = tag;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic expect_done(input logic [WW-1:0] wid, input logic [TW-1:0] tag);
    check_eq("R7", "done_valid", done_valid, 1);
    check_eq("R7", "done_wid", done_wid, wid);
    check_eq("R7", "done_tag", done_tag, tag);
    @(negedge clk);
    check_eq("R7", "done pulse ends", done_valid, 0);
  endtask

  // reference grouping computed from R1/R2 and drained transaction by transaction
  task automatic drain(input logic [NT-1:0] mask, input logic [SZW-1:0] size,
                       input logic [TW-1:0] tag, input int stall, output int ntx);
    logic [NT-1:0] rem;
    logic [NT-1:0] exp_m;
    logic [AW-1:0] exp_seg;
    int lead;
    rem = mask;
    ntx = 0;
    while (rem != '0) begin
      lead = -1;
      for (int i = 0; i < NT; i++) if (rem[i] && lead < 0) lead = i;
      exp_seg = lane_addr[lead] >> 7;
      exp_m = '0;
      for (int i = 0; i < NT; i++) if (rem[i] && ((lane_addr[i] >> 7) == exp_seg)) exp_m[i] = 1'b1;
      rem = rem & ~exp_m;
      if (ntx == 0 && stall > 0) begin
        tx_ready = 1'b0;
        for (int s = 0; s < stall; s++) begin
          check_eq("R4", "held tx_valid", tx_valid, 1);
          check_eq("R4", "held tx_tmask", tx_tmask, exp_m);
          check_eq("R4", "held tx_base", tx_base, exp_seg << 7);
          @(negedge clk);
        end
      end
      check_eq("R5", "tx_valid", tx_valid, 1);
      check_eq("R1", "tx_base", tx_base, exp_seg << 7);
      check_eq("R2", "tx_tmask", tx_tmask, exp_m);
      check_eq("R7", "tx_tag", tx_tag, tag);
      check_eq("R10", "tx_size", tx_size, size);
      tx_ready = 1'b1;
      @(negedge clk);
      tx_ready = 1'b0;
      ntx++;
    end
    check_eq("R3", "no extra transaction", tx_valid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; tx_ready = 1'b0; rsp_valid = 1'b0;
    req_wid = '0; req_mask = '0; req_size = '0; rsp_tag = '0;
    for (int i = 0; i < NT; i++) lane_addr[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_eq("R9", "req_ready", req_ready, 1);
    check_eq("R9", "tx_valid", tx_valid, 0);
    check_eq("R9", "done_valid", done_valid, 0);
  endtask

  task automatic t_one_segment;
    int n;
    for (int i = 0; i < NT; i++) lane_addr[i] = 32'h0000_1000 + 32'(i * 4);
    send_req(4'd1, 8'hFF, 2'd2);
    drain(8'hFF, 2'd2, 2'd0, 0, n);
    check_eq("R1", "one segment count", n, 1);
    send_rsp(2'd0);
    expect_done(4'd1, 2'd0);
  endtask

  task automatic t_scattered;
    int n;
    for (int i = 0; i < NT; i++) lane_addr[i] = 32'h0001_0000 + 32'(i * 128);
    send_req(4'd2, 8'hFF, 2'd1);
    drain(8'hFF, 2'd1, 2'd0, 0, n);
    check_eq("R1", "scattered count", n, 8);
    for (int k = 0; k < 7; k++) send_rsp(2'd0);
    check_eq("R7", "no done before last response", done_valid, 0);
    send_rsp(2'd0);
    expect_done(4'd2, 2'd0);
  endtask

  task automatic t_mixed_inactive;
    int n;
    lane_addr[0] = 32'h0000_2040; lane_addr[1] = 32'h0000_3000;
    lane_addr[2] = 32'h0000_2000; lane_addr[3] = 32'h0000_3010;
    lane_addr[4] = 32'h0000_2004; lane_addr[5] = 32'h0000_5000;
    lane_addr[6] = 32'h0000_3080; lane_addr[7] = 32'h0000_207C;
    send_req(4'd6, 8'b1011_0110, 2'd0);
    drain(8'b1011_0110, 2'd0, 2'd0, 0, n);
    check_eq("R3", "mixed count with inactive lanes", n, 3);
    send_rsp(2'd0);
    send_rsp(2'd0);
    check_eq("R7", "no done after two of three", done_valid, 0);
    send_rsp(2'd0);
    expect_done(4'd6, 2'd0);
  endtask

  task automatic t_zero_mask;
    send_req(4'd5, 8'h00, 2'd0);
    check_eq("R6", "no tx for empty mask", tx_valid, 0);
    expect_done(4'd5, 2'd0);
  endtask

  task automatic t_stall;
    int n;
    for (int i = 0; i < NT; i++) lane_addr[i] = 32'h0004_0000 + 32'((i % 2) * 256) + 32'(i);
    send_req(4'd7, 8'hFF, 2'd3);
    drain(8'hFF, 2'd3, 2'd0, 3, n);
    check_eq("R1", "two segment count", n, 2);
    send_rsp(2'd0);
    send_rsp(2'd0);
    expect_done(4'd7, 2'd0);
  endtask

  task automatic t_table_full;
    int n;
    for (int i = 0; i < NT; i++) lane_addr[i] = 32'h0008_0000;
    for (int r = 0; r < 4; r++) begin
      send_req(4'(r + 1), 8'h01, 2'd0);
      drain(8'h01, 2'd0, 2'(r), 0, n);
    end
    check_eq("R8", "ready low when table full", req_ready, 0);
    req_valid = 1'b1; req_wid = 4'd12; req_mask = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    check_eq("R8", "refused request emits nothing", tx_valid, 0);
    check_eq("R8", "still refused", req_ready, 0);
    req_valid = 1'b0;
    send_rsp(2'd2);
    expect_done(4'd3, 2'd2);
    check_eq("R8", "ready after free", req_ready, 1);
    send_req(4'd9, 8'h01, 2'd1);
    drain(8'h01, 2'd1, 2'd2, 0, n);
    send_rsp(2'd3);
    expect_done(4'd4, 2'd3);
    send_rsp(2'd0);
    expect_done(4'd1, 2'd0);
    send_rsp(2'd2);
    expect_done(4'd9, 2'd2);
    send_rsp(2'd1);
    expect_done(4'd2, 2'd1);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
  endtask

  initial begin
    n_vec = 0; n_err = 0; finished = 1'b0;
    t_reset();
    t_one_segment();
    t_scattered();
    t_mixed_inactive();
    t_zero_mask();
    t_stall();
    t_table_full();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

endmodule